// File: doc/BRIEF.md
# Configurable Serial Character Receiver

This block turns an asynchronous serial line into characters. A mode register sets its behaviour: one bit enables reception, a two-bit field selects no parity, an unchecked parity slot, odd parity or even parity, one bit selects 7 or 8 data bits, and one bit decides whether a frame with an error still raises the completion interrupt. An external enable pulse, `os_tick_i`, runs at sixteen times the bit rate. After a two-flop synchroniser, the receiver finds the falling edge of a start bit. It confirms the start bit at the half-bit point and then samples every later bit at the centre of the bit.

Each finished frame loads a holding register with the character and with its parity, framing and overrun flags. The holding register is marked full until the consumer pulses `rd_i`. The completion interrupt is a one-cycle pulse. It appears in the same cycle as the new data.

Top module: `serial_rx`

## Requirements
- R1: When mode bit 6 is 0, the receiver stays idle. Line activity produces no frame, no interrupt and no change to data or flags.
- R2: Mode bit 3 selects the character length: 1 means 8 data bits and 0 means 7 data bits, received least significant bit first. Parity field (bits 5:4) = 00 means no parity slot follows the data, and a parity error is never reported.
- R3: Parity field = 01 means one parity slot follows the data. The receiver consumes it but never checks it, so a parity error is never reported.
- R4: Parity field = 10 checks odd parity and 11 checks even parity, computed over the data bits plus the parity bit. A mismatch sets `parity_err_o` for that frame.
- R5: In 7-bit mode, `data_o[7]` reads 0.
- R6: Exactly one stop bit is sampled. If it is 0, `frame_err_o` is set for that frame.
- R7: A falling edge counts as a start bit only if the line is still low 8 ticks later. Otherwise the receiver returns to idle without producing a frame.
- R8: If a frame completes while the holding register is still full and `rd_i` is not high in that cycle, `overrun_err_o` is set and the new character replaces the old one.
- R9: `rx_irq_o` is a one-cycle pulse per completed frame. When mode bit 1 is 1, frames carrying any error flag raise no pulse. When bit 1 is 0, every frame raises one.
- R10: The mode register resets to 0x00, and bit 0 always reads 0.
- R11: After a frame whose stop bit was 0, no new start bit is accepted until the line has been seen high.
- R12: All flags and the data are replaced at each completed frame. `valid_o` is set when a frame completes and is cleared by `rd_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_we_i | input | 1 | Mode register write strobe |
| mode_wdata_i | input | 8 | Mode register write data |
| mode_o | output | 8 | Mode register contents |
| os_tick_i | input | 1 | Enable pulse at 16x the bit rate |
| rx_i | input | 1 | Serial line, idle high |
| rd_i | input | 1 | Holding register read strobe |
| data_o | output | 8 | Received character |
| valid_o | output | 1 | Holding register full |
| parity_err_o | output | 1 | Parity error of the last frame |
| frame_err_o | output | 1 | Framing error of the last frame |
| overrun_err_o | output | 1 | Overrun on the last frame |
| rx_irq_o | output | 1 | Receive-complete interrupt pulse |

## Verification
A bit counter that is one off changes the character width, or moves the parity slot onto the stop bit. That shows up at the next completion as a shifted `data_o` or a false parity or framing flag. An oversampling counter that is off by a few ticks skews every sample point, and data becomes corrupt within a frame or two of fast-changing bits. A stuck rearm flag or a wrong error-gating term shows up as a missing or extra `rx_irq_o` pulse in the cycle the holding register updates.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int CHAR_W   = 8;
  localparam int MODE_W   = 8;
  localparam int EN_BIT   = 6;
  localparam int PAR_HI   = 5;
  localparam int PAR_LO   = 4;
  localparam int LEN_BIT  = 3;
  localparam int GATE_BIT = 1;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP
  } rx_state_e;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_ZERO = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_EVEN = 2'b11
  } par_mode_e;

  typedef struct packed {
    logic [CHAR_W-1:0] data;
    logic              par_err;
    logic              frm_err;
  } rx_frame_t;
endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/serial_rx_mode.sv
module serial_rx_mode
  import serial_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [MODE_W-1:0] wdata_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              en_o,
  output par_mode_e         par_o,
  output logic              len8_o,
  output logic              gate_o
);
  logic [MODE_W-1:0] mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mode_q <= '0;
    else if (we_i) mode_q <= {wdata_i[MODE_W-1:1], 1'b0};  // bit 0 reserved
  end

  assign mode_o = mode_q;
  assign en_o   = mode_q[EN_BIT];
  assign par_o  = par_mode_e'(mode_q[PAR_HI:PAR_LO]);
  assign len8_o = mode_q[LEN_BIT];
  assign gate_o = mode_q[GATE_BIT];
endmodule

// File: rtl/serial_rx_deser.sv
module serial_rx_deser
  import serial_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      rx_i,
  input  logic      en_i,
  input  par_mode_e par_i,
  input  logic      len8_i,
  output logic      done_o,
  output rx_frame_t frame_o
);
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(CHAR_W);
  localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  rx_state_e         state_q;
  logic [CW-1:0]     os_cnt_q;
  logic [BW-1:0]     bit_cnt_q;
  logic [CHAR_W-1:0] shreg_q;
  logic              par_bit_q;
  logic              armed_q;
  logic              done_q;
  rx_frame_t         frame_q;

  logic [BW-1:0]     last_bit;
  logic [CHAR_W-1:0] char_w;
  logic              par_err_w;

  assign last_bit = len8_i ? BW'(CHAR_W-1) : BW'(CHAR_W-2);
  assign char_w   = len8_i ? shreg_q : {1'b0, shreg_q[CHAR_W-1:1]};

  always_comb begin
    unique case (par_i)
      PAR_ODD:  par_err_w = ~(^char_w ^ par_bit_q);
      PAR_EVEN: par_err_w = ^char_w ^ par_bit_q;
      default:  par_err_w = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      os_cnt_q  <= '0;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      par_bit_q <= 1'b0;
      armed_q   <= 1'b1;
      done_q    <= 1'b0;
      frame_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!en_i) begin
        state_q  <= S_IDLE;
        os_cnt_q <= '0;
      end else if (tick_i) begin
        unique case (state_q)
          S_IDLE: begin
            if (rx_i) armed_q <= 1'b1;
            else if (armed_q) begin
              state_q  <= S_START;
              os_cnt_q <= '0;
            end
          end
          S_START: begin
            if (os_cnt_q == MID) begin
              os_cnt_q  <= '0;
              bit_cnt_q <= '0;
              state_q   <= rx_i ? S_IDLE : S_DATA;  // reject glitch
            end else os_cnt_q <= os_cnt_q + 1'b1;
          end
          S_DATA: begin
            if (os_cnt_q == LAST) begin
              os_cnt_q  <= '0;
              shreg_q   <= {rx_i, shreg_q[CHAR_W-1:1]};
              bit_cnt_q <= bit_cnt_q + 1'b1;
              if (bit_cnt_q == last_bit)
                state_q <= (par_i == PAR_NONE) ? S_STOP : S_PAR;
            end else os_cnt_q <= os_cnt_q + 1'b1;
          end
          S_PAR: begin
            if (os_cnt_q == LAST) begin
              os_cnt_q  <= '0;
              par_bit_q <= rx_i;
              state_q   <= S_STOP;
            end else os_cnt_q <= os_cnt_q + 1'b1;
          end
          S_STOP: begin
            if (os_cnt_q == LAST) begin
              os_cnt_q        <= '0;
              state_q         <= S_IDLE;
              armed_q         <= rx_i;  // low stop: wait for mark
              done_q          <= 1'b1;
              frame_q.data    <= char_w;
              frame_q.par_err <= par_err_w;
              frame_q.frm_err <= ~rx_i;
            end else os_cnt_q <= os_cnt_q + 1'b1;
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  assign done_o  = done_q;
  assign frame_o = frame_q;
endmodule

// File: rtl/serial_rx_hold.sv
module serial_rx_hold
  import serial_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  rx_frame_t         frame_i,
  input  logic              rd_i,
  input  logic              gate_i,
  output logic [CHAR_W-1:0] data_o,
  output logic              valid_o,
  output logic              par_err_o,
  output logic              frm_err_o,
  output logic              ovr_err_o,
  output logic              irq_o
);
  logic [CHAR_W-1:0] data_q;
  logic valid_q, pe_q, fe_q, ovr_q, irq_q;
  logic ovr_w;

  assign ovr_w = valid_q & ~rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      pe_q    <= 1'b0;
      fe_q    <= 1'b0;
      ovr_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (done_i) begin
        data_q  <= frame_i.data;
        pe_q    <= frame_i.par_err;
        fe_q    <= frame_i.frm_err;
        ovr_q   <= ovr_w;
        valid_q <= 1'b1;
        irq_q   <= ~(gate_i & (frame_i.par_err | frame_i.frm_err | ovr_w));
      end else if (rd_i) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign data_o    = data_q;
  assign valid_o   = valid_q;
  assign par_err_o = pe_q;
  assign frm_err_o = fe_q;
  assign ovr_err_o = ovr_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/serial_rx.sv
module serial_rx
  import serial_rx_pkg::*;
#(
  parameter int OSR       = 16,
  parameter int SYNC_DEPTH = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mode_we_i,
  input  logic [7:0] mode_wdata_i,
  output logic [7:0] mode_o,
  input  logic       os_tick_i,
  input  logic       rx_i,
  input  logic       rd_i,
  output logic [7:0] data_o,
  output logic       valid_o,
  output logic       parity_err_o,
  output logic       frame_err_o,
  output logic       overrun_err_o,
  output logic       rx_irq_o
);
  logic      rx_sync;
  logic      en, len8, gate;
  par_mode_e par;
  logic      frame_done;
  rx_frame_t frame;

  serial_rx_sync #(.STAGES(SYNC_DEPTH)) i_sync (
    .clk_i, .rst_ni, .d_i(rx_i), .q_o(rx_sync)
  );

  serial_rx_mode i_mode (
    .clk_i, .rst_ni, .we_i(mode_we_i), .wdata_i(mode_wdata_i),
    .mode_o, .en_o(en), .par_o(par), .len8_o(len8), .gate_o(gate)
  );

  serial_rx_deser #(.OSR(OSR)) i_deser (
    .clk_i, .rst_ni, .tick_i(os_tick_i), .rx_i(rx_sync), .en_i(en),
    .par_i(par), .len8_i(len8), .done_o(frame_done), .frame_o(frame)
  );

  serial_rx_hold i_hold (
    .clk_i, .rst_ni, .done_i(frame_done), .frame_i(frame), .rd_i,
    .gate_i(gate), .data_o, .valid_o, .par_err_o(parity_err_o),
    .frm_err_o(frame_err_o), .ovr_err_o(overrun_err_o), .irq_o(rx_irq_o)
  );
endmodule

// File: rtl/serial_rx_chk.sv
module serial_rx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] mode_o,
  input logic       frame_done,
  input logic       rd_i,
  input logic       valid_o,
  input logic [7:0] data_o,
  input logic       parity_err_o,
  input logic       frame_err_o,
  input logic       overrun_err_o,
  input logic       rx_irq_o
);
  p_off_no_frame_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_o[6] |=> !frame_done);

  p_no_par_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done && mode_o[5:4] == 2'b00) |=> !parity_err_o);

  p_zero_par_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done && mode_o[5:4] == 2'b01) |=> !parity_err_o);

  p_bit7_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done && !mode_o[3]) |=> !data_o[7]);

  p_overrun_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done && valid_o && !rd_i) |=> overrun_err_o);

  p_gate_err_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_irq_o && mode_o[1]) |-> !(parity_err_o || frame_err_o || overrun_err_o));

  p_irq_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |=> !rx_irq_o);

  p_mode_bit0_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_o[0]);

  p_valid_set_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done |=> valid_o);
endmodule

bind serial_rx serial_rx_chk i_serial_rx_chk (.*);

// File: tb/test_serial_rx.sv
module test_serial_rx;
  localparam int BIT = 32;  // 16 ticks, one tick every 2 clocks

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_we = 1'b0;
  logic [7:0] mode_wdata = '0;
  logic [7:0] mode_rd;
  logic       tick = 1'b0;
  logic       rx = 1'b1;
  logic       rd = 1'b0;
  logic [7:0] data;
  logic       valid, pe, fe, ovr, irq;

  int n_cmp = 0, n_bad = 0, irq_cnt = 0;
  bit finished = 1'b0;
  logic [7:0] m_cur = '0;
  logic [7:0] exp_data = '0;
  logic       exp_full = 1'b0, exp_pe = 1'b0, exp_fe = 1'b0, exp_ovr = 1'b0;

  serial_rx i_serial_rx (
    .clk_i(clk), .rst_ni(rst_n), .mode_we_i(mode_we), .mode_wdata_i(mode_wdata),
    .mode_o(mode_rd), .os_tick_i(tick), .rx_i(rx), .rd_i(rd), .data_o(data),
    .valid_o(valid), .parity_err_o(pe), .frame_err_o(fe),
    .overrun_err_o(ovr), .rx_irq_o(irq)
  );

  always #10 clk = ~clk;

  initial forever begin
    @(negedge clk);
    tick = ~tick;
    if (irq) irq_cnt++;
  end

  task automatic check(input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  function automatic logic par_bit(input logic [7:0] c, input logic [1:0] pm);
    case (pm)
      2'b10:   return ~^c;
      2'b11:   return ^c;
      default: return 1'b0;
    endcase
  endfunction

  task automatic set_mode(input logic [7:0] m);
    @(negedge clk); mode_we = 1'b1; mode_wdata = m;
    @(negedge clk); mode_we = 1'b0;
    m_cur = {m[7:1], 1'b0};
  endtask

  task automatic read_hold();
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    exp_full = 1'b0;
  endtask

  task automatic drive(input logic v, input int cycles);
    rx = v;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] d, input logic bad_par,
                       input logic bad_stop, input int extra_low);
    int nb = m_cur[3] ? 8 : 7;
    logic [7:0] c = m_cur[3] ? d : {1'b0, d[6:0]};
    int irq0 = irq_cnt;
    logic e_irq;
    drive(1'b0, BIT);
    for (int i = 0; i < nb; i++) drive(d[i], BIT);
    if (m_cur[5:4] != 2'b00) drive(par_bit(c, m_cur[5:4]) ^ bad_par, BIT);
    drive(!bad_stop, BIT);
    if (bad_stop && extra_low > 0) drive(1'b0, extra_low);
    drive(1'b1, 2 * BIT);
    if (m_cur[6]) begin
      exp_data = c;
      exp_pe   = m_cur[5] & bad_par;
      exp_fe   = bad_stop;
      exp_ovr  = exp_full;
      exp_full = 1'b1;
      e_irq    = !(m_cur[1] && (exp_pe || exp_fe || exp_ovr));
    end else e_irq = 1'b0;
    check("R12 data", int'(data), int'(exp_data));
    check("R4 parity_err", int'(pe), int'(exp_pe));
    check("R6 frame_err", int'(fe), int'(exp_fe));
    check("R8 overrun", int'(ovr), int'(exp_ovr));
    check("R9 irq count", irq_cnt - irq0, int'(e_irq));
    check("R12 valid", int'(valid), int'(exp_full));
  endtask

  initial begin
    int irq0;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 mode reset", int'(mode_rd), 0);
    check("R12 valid reset", int'(valid), 0);
    check("R9 irq reset", int'(irq), 0);

    set_mode(8'hFF);
    check("R10 bit0 reads 0", int'(mode_rd), 8'hFE);

    // R1: disabled receiver
    set_mode(8'h08);
    frame(8'hA5, 1'b0, 1'b0, 0);
    check("R1 disabled no data", int'(valid), 0);

    // R2: 8 bits no parity, then 7 bits
    set_mode(8'h48);
    frame(8'h3C, 1'b0, 1'b0, 0);
    read_hold();
    set_mode(8'h40);
    frame(8'hFF, 1'b0, 1'b0, 0);
    check("R5 bit7 zero", int'(data[7]), 0);
    read_hold();

    // R3: unchecked parity slot with a wrong bit
    set_mode(8'h58);
    frame(8'h81, 1'b1, 1'b0, 0);
    check("R3 zero parity unchecked", int'(pe), 0);
    read_hold();

    // R4: odd and even, good and bad
    set_mode(8'h68); frame(8'h17, 1'b0, 1'b0, 0); read_hold();
    set_mode(8'h68); frame(8'h17, 1'b1, 1'b0, 0); read_hold();
    set_mode(8'h78); frame(8'hC3, 1'b1, 1'b0, 0); read_hold();
    set_mode(8'h70); frame(8'h55, 1'b0, 1'b0, 0); read_hold();

    // R9: gated error frame produces no pulse
    set_mode(8'h6A); frame(8'h17, 1'b1, 1'b0, 0); read_hold();

    // R8: overrun without read
    set_mode(8'h48);
    frame(8'h11, 1'b0, 1'b0, 0);
    frame(8'h22, 1'b0, 1'b0, 0);
    check("R8 overrun set", int'(ovr), 1);
    read_hold();

    // R7: short low glitch rejected
    irq0 = irq_cnt;
    drive(1'b0, 8);
    drive(1'b1, 2 * BIT);
    check("R7 glitch no irq", irq_cnt - irq0, 0);
    check("R7 glitch no data", int'(valid), 0);

    // R11: low stop followed by long low, one frame only
    frame(8'h5A, 1'b0, 1'b1, 3 * BIT);
    read_hold();
    frame(8'h69, 1'b0, 1'b0, 0);
    check("R11 rearm data", int'(data), 8'h69);
    read_hold();

    // random mix
    for (int k = 0; k < 36; k++) begin
      logic [7:0] m;
      m = {1'b0, ($urandom % 8) != 0, 2'($urandom), 1'($urandom), 1'b0, 1'($urandom), 1'b0};
      set_mode(m);
      if ($urandom % 2) read_hold();
      frame(8'($urandom), ($urandom % 4) == 0, ($urandom % 6) == 0, 0);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule